// File: doc/BRIEF.md
# Serial Test Point Access Unit

This block lets a tester reach many internal observation and control points of a circuit under test through three pins: one serial data input, one serial observation output and a test-enable. A single select counter runs while test-enable is high. It steps through the point indices 0 to N-1 and then starts again at 0. In each cycle the counter value selects which observation point is routed to the test output, and which bit of an N-bit control register takes the serial input.

A full sweep of the observations therefore costs N cycles per test vector. Loading a complete set of control values also costs N cycles, one bit per cycle in index order. This trade of test time against pins is the purpose of the block. A one-cycle marker is high in the cycle that holds index N-1. A tester can use it to line its vector boundaries up with the sweep. Dropping test-enable returns the counter to index 0, and the stored control values stay frozen.

Top module: `tpa_access_unit`

## Requirements
- R1: After an asynchronous reset (rst_n low), every control output is 0, the select index is 0 and the frame marker is low.
- R2: While test_en is low, the select index stays at 0: test_out equals obs_pts[0] and frame_mark is low.
- R3: While test_en is high, the index advances by one at each rising clock edge. In the k-th enabled cycle after test_en was sampled low (counting from 0), test_out equals obs_pts[k mod N].
- R4: frame_mark is high in exactly the cycles where test_en is high and the index is N-1. With test_en held high, it is therefore a one-cycle pulse every N cycles.
- R5: At a rising edge where test_en is high and the index is k, ctrl_pts[k] takes the value of z_in.
- R6: A control bit whose index is not selected keeps its value. While test_en is low, z_in has no effect on ctrl_pts.
- R7: When test_en goes low in the middle of a sweep, the sweep restarts at index 0 once test_en is high again.
- R8: Any N-bit control pattern is fully loaded after N enabled cycles that start from index 0, when bit k is driven on z_in in the cycle with index k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Runs the select counter and enables control-bit writes |
| obs_pts | input | N | Observation points from the circuit under test |
| z_in | input | 1 | Serial control-value input |
| test_out | output | 1 | Observation point selected by the current index |
| ctrl_pts | output | N | Stored control-point values |
| frame_mark | output | 1 | High in the cycle whose index is N-1 while enabled |

## Verification
The assertions assume that test_en and z_in are synchronous to clk and stable around the rising edge. They also assume that rst_n is asserted from time zero until the first check. The bench meets this by driving every input shortly after a falling edge and by holding reset over several edges. It sweeps all 2^N control patterns for the default N = 8, each in its own aligned sweep, and moves a walking pattern over obs_pts so that every index is seen at the output. Test-enable is also dropped in the middle of a sweep, and z_in toggles while the block is disabled.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

  // Width of an index that covers n points (at least one bit)
  function automatic int unsigned sel_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Next index in a sweep of n points, wrapping at n-1
  function automatic int unsigned step_index(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/tpa_sel_counter.sv
module tpa_sel_counter #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEL_W = tpa_pkg::sel_width(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [SEL_W-1:0] sel,
  output logic             lap_end
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel <= '0;
    else if (!en)
      sel <= '0;
    else
      sel <= SEL_W'(tpa_pkg::step_index(32'(sel), N));
  end

  assign lap_end = en && (sel == LAST);

  // R2 / R7: a disabled cycle leaves the index at zero
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sel == '0));

  // R3: enabled cycles below the last index step by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel != LAST) |=> (sel == $past(sel) + 1'b1));

  // R4: the last index is followed by index zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel == LAST) |=> (sel == '0));

  // R4: the lap marker never lasts two cycles
  p_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lap_end |=> !lap_end);

endmodule

// File: rtl/tpa_obs_mux.sv
module tpa_obs_mux #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEL_W = tpa_pkg::sel_width(N)
) (
  input  logic [N-1:0]     pts,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N; i++)
      if (sel == SEL_W'(i)) y = pts[i];
  end
endmodule

// File: rtl/tpa_ctrl_latch.sv
module tpa_ctrl_latch #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEL_W = tpa_pkg::sel_width(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             z,
  output logic [N-1:0]     q
);
  logic [N-1:0] wr_hot;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign wr_hot[g] = en && (sel == SEL_W'(g));

    // R5: the addressed bit captures the serial input
    p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sel == SEL_W'(g)) |=> (q[g] == $past(z)));

    // R6: an unaddressed bit, or any bit while disabled, holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || sel != SEL_W'(g)) |=> $stable(q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else
      for (int i = 0; i < N; i++)
        if (wr_hot[i]) q[i] <= z;
  end
endmodule

// File: rtl/tpa_access_unit.sv
module tpa_access_unit #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic [N-1:0] obs_pts,
  input  logic         z_in,
  output logic         test_out,
  output logic [N-1:0] ctrl_pts,
  output logic         frame_mark
);
  localparam int unsigned SEL_W = tpa_pkg::sel_width(N);

  logic [SEL_W-1:0] idx;
  logic             lap_end;

  tpa_sel_counter #(.N(N), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(test_en), .sel(idx), .lap_end(lap_end)
  );

  tpa_obs_mux #(.N(N), .SEL_W(SEL_W)) u_mux (
    .pts(obs_pts), .sel(idx), .y(test_out)
  );

  tpa_ctrl_latch #(.N(N), .SEL_W(SEL_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .en(test_en), .sel(idx), .z(z_in), .q(ctrl_pts)
  );

  assign frame_mark = lap_end;

  // R1: the marker is low while reset is held
  p_reset_r1: assert property (@(posedge clk) !rst_n |-> !frame_mark);

endmodule

// File: tb/tpa_access_unit_tb.sv
`timescale 1ns/1ps
module tpa_access_unit_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         test_en = 1'b0;
  logic [N-1:0] obs_pts = '0;
  logic         z_in = 1'b0;
  logic         test_out;
  logic [N-1:0] ctrl_pts;
  logic         frame_mark;

  int checks = 0;
  int fails  = 0;
  int exp_idx = 0;
  logic [N-1:0] exp_ctrl = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tpa_access_unit #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .obs_pts(obs_pts),
    .z_in(z_in), .test_out(test_out), .ctrl_pts(ctrl_pts), .frame_mark(frame_mark)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive inputs after a falling edge, check the combinational
  // outputs, advance the model, then check the registered control bits.
  task automatic step(input logic en, input logic z, input logic [N-1:0] obs);
    test_en = en; z_in = z; obs_pts = obs;
    #0.5;
    chk(en ? "R3 test_out" : "R2 test_out", 32'(test_out), 32'(obs[exp_idx]));
    chk("R4 frame_mark", 32'(frame_mark), 32'(en && exp_idx == N-1));
    if (en) begin
      exp_ctrl[exp_idx] = z;
      exp_idx = (exp_idx + 1) % N;
    end else begin
      exp_idx = 0;
    end
    @(negedge clk);
    chk(en ? "R5 ctrl_pts" : "R6 ctrl_pts", 32'(ctrl_pts), 32'(exp_ctrl));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1 ctrl_pts", 32'(ctrl_pts), 0);
    chk("R1 frame_mark", 32'(frame_mark), 0);
    obs_pts = 8'h01; #0.5;
    chk("R1 test_out", 32'(test_out), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R6: disabled, z toggling, walking observation pattern
    for (int i = 0; i < 2*N; i++)
      step(1'b0, i[0], N'(1) << (i % N));

    // R3 / R4: walking one and walking zero over several laps
    for (int i = 0; i < 3*N; i++)
      step(1'b1, 1'b0, N'(1) << (i % N));
    for (int i = 0; i < 2*N; i++)
      step(1'b1, 1'b1, ~(N'(1) << ((i + 3) % N)));

    // R7: drop enable mid-sweep, then restart from index 0
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, N'(8'hA5));
    step(1'b0, 1'b1, N'(8'h5A));
    step(1'b0, 1'b0, N'(8'h5A));
    for (int i = 0; i < N; i++) step(1'b1, 1'b1, N'(1) << i);
    step(1'b0, 1'b0, '0);

    // R8: every control pattern loaded in one aligned sweep
    for (int p = 0; p < (1 << N); p++) begin
      for (int k = 0; k < N; k++)
        step(1'b1, p[k], N'(p) ^ N'(k * 37));
      chk("R8 pattern", 32'(ctrl_pts), 32'(p));
    end

    // R6: pattern holds while disabled with z toggling
    for (int i = 0; i < N; i++) step(1'b0, ~i[0], '1);
    chk("R6 hold", 32'(ctrl_pts), 32'((1 << N) - 1));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule